// File: doc/BRIEF.md
# Staged Escalation Watchdog Controller

This block is a watchdog that escalates instead of firing once. It watches the expiry pulses of one timer, picked from a bank of timers by a selection field. After a programmed number of those pulses, one watchdog expiration has elapsed. Each expiration moves the watchdog one step along a fixed five-step ladder:

1. local interrupt
2. local fast interrupt
3. remote interrupt
4. debug reset
5. power-on reset

A step produces its output only when that step's enable bit is set. The ladder advances whether or not the output was produced.

Software controls the block through a small register port. It writes a configuration word and issues start and disable commands. A command is honoured only when an unlock word was written just before it. Software pets the watchdog by doing an unlock-and-disable followed by an unlock-and-start. This clears the ladder and any raised interrupts and begins a new count. The timers themselves are outside this block, and so is the distribution of its reset pulses.

Top module: `wdog_escalator`

## Requirements
- R1: The configuration register at address 0 holds 17 bits, and reading address 0 returns those bits with bits 31:17 as zero. Its fields are:
  - bits 3:0: timer source
  - bits 11:4: period
  - bit 12: local-interrupt enable
  - bit 13: fast-interrupt enable
  - bit 14: remote-interrupt enable
  - bit 15: debug-reset enable
  - bit 16: power-on-reset enable
- R2: Only expiry pulses on the timer input whose index equals the source field are counted. A source value of NUM_TIMERS or above counts nothing.
- R3: One watchdog expiration occurs on every period-th counted pulse. A period of 0 behaves as a period of 1.
- R4: The actions follow the expiration number: the 1st is the local interrupt, the 2nd the fast interrupt, the 3rd the remote interrupt, the 4th the debug reset and the 5th the power-on reset.
- R5: A step whose enable bit is clear produces no output, but it still consumes its expiration.
- R6: Writing 0x0000C45A to address 2 arms the controller, and writing any other value there disarms it. A write to the command register at address 1 is honoured only while the controller is armed, and every command write disarms it. An unarmed command write changes nothing.
- R7: In a command write, bit 1 means disable and bit 0 means start. If both bits are set, disable wins. An honoured start clears the pulse count, the step and the interrupts, then begins counting.
- R8: An honoured disable stops counting and clears the pulse count, the step and all three interrupt outputs.
- R9: Interrupt outputs rise one cycle after the counted pulse and stay high until an honoured command. Reset outputs are single-cycle pulses.
- R10: After the fifth expiration, counting halts. No further pulses produce any action until the watchdog is restarted.
- R11: Reading address 1 returns the running flag in bit 0 and the step number (0 to 5) in bits 6:4. All other read bits are zero.
- R12: After reset, all outputs are low, the configuration is zero, the controller is stopped and it is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 config, 1 command, 2 unlock) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (0 config, 1 status) |
| rd_data | output | 32 | Combinational read data |
| tmr_expire | input | NUM_TIMERS | One expiry pulse per timer |
| irq_local | output | 1 | Sticky local interrupt |
| irq_fast | output | 1 | Sticky local fast interrupt |
| irq_remote | output | 1 | Sticky remote interrupt |
| rst_debug | output | 1 | One-cycle debug reset pulse |
| rst_por | output | 1 | One-cycle power-on reset pulse |

## Verification
The ladder is run several ways:

- with all steps enabled and a period of two, which shows that pulses are counted per expiration and that the step order is right;
- with only the final step enabled, which separates gating from sequencing;
- with a period of zero, which exposes off-by-one errors in the period count.

Pulses on non-selected and out-of-range timers are mixed in to separate source selection from counting. Command patterns are also tried:

- no unlock;
- a wrong unlock word;
- an unlock consumed by an earlier command;
- both command bits set together.

These show whether the unlock is single-use and which command takes precedence. A behavioural model compared on every clock catches effects that fall between the directed checks.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;
    localparam int CFG_W      = 17;
    localparam int SRC_W      = 4;
    localparam int PER_W      = 8;
    localparam int PER_LSB    = 4;
    localparam int EN_LSB     = 12;
    localparam int N_STEPS    = 5;
    localparam int STEP_W     = 3;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_CMD = 2'd1;
    localparam logic [1:0] ADDR_KEY = 2'd2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              armed;
        logic              running;
        logic [PER_W-1:0]  count;
        logic [STEP_W-1:0] stage;
        logic [2:0]        irq;
        logic [1:0]        rst;
    } wdog_state_t;
endpackage

// File: rtl/wdog_src_sel.sv
module wdog_src_sel #(
    parameter int NUM_TIMERS = 10,
    parameter int SEL_W      = 4
) (
    input  logic [NUM_TIMERS-1:0] tmr_expire,
    input  logic [SEL_W-1:0]      sel,
    output logic                  pulse
);
    logic [NUM_TIMERS-1:0] hit;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_hit
        assign hit[i] = tmr_expire[i] && (sel == SEL_W'(i));
    end

    assign pulse = |hit;
endmodule

// File: rtl/wdog_period_ctr.sv
module wdog_period_ctr #(
    parameter int PER_W = 8
) (
    input  logic [PER_W-1:0] count_q,
    input  logic [PER_W-1:0] period,
    input  logic             tick,
    output logic [PER_W-1:0] count_d,
    output logic             expire
);
    logic [PER_W:0] limit;
    logic [PER_W:0] next;

    always_comb begin
        limit   = (period == '0) ? (PER_W+1)'(1) : {1'b0, period};
        next    = {1'b0, count_q} + (PER_W+1)'(1);
        count_d = count_q;
        expire  = 1'b0;
        if (tick) begin
            if (next >= limit) begin
                expire  = 1'b1;
                count_d = '0;
            end else begin
                count_d = next[PER_W-1:0];
            end
        end
    end
endmodule

// File: rtl/wdog_stage_dec.sv
module wdog_stage_dec #(
    parameter int N_STEPS = 5,
    parameter int STEP_W  = 3
) (
    input  logic [STEP_W-1:0]  stage_q,
    input  logic               expire,
    input  logic [N_STEPS-1:0] en,
    output logic [STEP_W-1:0]  stage_d,
    output logic [N_STEPS-1:0] act
);
    logic room;
    assign room = (stage_q < STEP_W'(N_STEPS));

    for (genvar k = 0; k < N_STEPS; k++) begin : g_act
        assign act[k] = expire && room && (stage_q == STEP_W'(k)) && en[k];
    end

    assign stage_d = (expire && room) ? stage_q + STEP_W'(1) : stage_q;
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdog_esc_pkg::*;
#(
    parameter int          NUM_TIMERS  = 10,
    parameter logic [31:0] UNLOCK_WORD = 32'h0000_C45A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [1:0]            rd_addr,
    output logic [31:0]           rd_data,
    input  logic [NUM_TIMERS-1:0] tmr_expire,
    output logic                  irq_local,
    output logic                  irq_fast,
    output logic                  irq_remote,
    output logic                  rst_debug,
    output logic                  rst_por
);
    wdog_state_t state_q, state_d;

    logic              sel_pulse;
    logic              tick;
    logic              expire;
    logic [PER_W-1:0]  count_nx;
    logic [STEP_W-1:0] stage_nx;
    logic [N_STEPS-1:0] act;

    wdog_src_sel #(.NUM_TIMERS(NUM_TIMERS), .SEL_W(SRC_W)) u_sel (
        .tmr_expire (tmr_expire),
        .sel        (state_q.cfg[SRC_W-1:0]),
        .pulse      (sel_pulse)
    );

    assign tick = state_q.running && (state_q.stage < STEP_W'(N_STEPS)) && sel_pulse;

    wdog_period_ctr #(.PER_W(PER_W)) u_per (
        .count_q (state_q.count),
        .period  (state_q.cfg[PER_LSB +: PER_W]),
        .tick    (tick),
        .count_d (count_nx),
        .expire  (expire)
    );

    wdog_stage_dec #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_dec (
        .stage_q (state_q.stage),
        .expire  (expire),
        .en      (state_q.cfg[EN_LSB +: N_STEPS]),
        .stage_d (stage_nx),
        .act     (act)
    );

    always_comb begin
        state_d     = state_q;
        state_d.rst = '0;
        if (tick) begin
            state_d.count = count_nx;
            state_d.stage = stage_nx;
            state_d.irq   = state_q.irq | act[2:0];
            state_d.rst   = act[4:3];
        end
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CFG: state_d.cfg   = wr_data[CFG_W-1:0];
                ADDR_KEY: state_d.armed = (wr_data == UNLOCK_WORD);
                ADDR_CMD: begin
                    state_d.armed = 1'b0;
                    if (state_q.armed &&
                        (wr_data[CMD_STOP_BIT] || wr_data[CMD_START_BIT])) begin
                        state_d.running = !wr_data[CMD_STOP_BIT];
                        state_d.count   = '0;
                        state_d.stage   = '0;
                        state_d.irq     = '0;
                        state_d.rst     = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CFG: rd_data[CFG_W-1:0] = state_q.cfg;
            ADDR_CMD: begin
                rd_data[0]   = state_q.running;
                rd_data[6:4] = state_q.stage;
            end
            default: ;
        endcase
    end

    assign irq_local  = state_q.irq[0];
    assign irq_fast   = state_q.irq[1];
    assign irq_remote = state_q.irq[2];
    assign rst_debug  = state_q.rst[0];
    assign rst_por    = state_q.rst[1];
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       cmd_dis,
    input logic       armed,
    input logic       running,
    input logic [2:0] stage,
    input logic       irq_local,
    input logic       irq_fast,
    input logic       irq_remote,
    input logic       rst_debug,
    input logic       rst_por
);
    assert_locked_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !armed) |=> $stable(running));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && armed && cmd_dis) |=>
            (!running && stage == 3'd0 && !irq_local && !irq_fast && !irq_remote));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_local) || $fell(irq_fast) || $fell(irq_remote)) |->
            $past(cmd_wr && armed));

    assert_debug_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_debug |=> !rst_debug);

    assert_por_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_por |=> !rst_por);

    assert_por_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_por |-> (stage == 3'd5));

    assert_debug_fourth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_debug |-> (stage == 3'd4));

    assert_stage_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stage <= 3'd5);

    assert_one_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_debug, rst_por}));
endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (wr_en && (wr_addr == 2'd1)),
    .cmd_dis    (wr_data[1]),
    .armed      (state_q.armed),
    .running    (state_q.running),
    .stage      (state_q.stage),
    .irq_local  (irq_local),
    .irq_fast   (irq_fast),
    .irq_remote (irq_remote),
    .rst_debug  (rst_debug),
    .rst_por    (rst_por)
);

// File: tb/wdog_escalator_tb_top.sv
module wdog_escalator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 10;
    localparam int KEY = 32'h0000_C45A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NT-1:0] tmr_expire = '0;
    logic irq_local, irq_fast, irq_remote, rst_debug, rst_por;

    int checks = 0;
    int fails  = 0;

    wdog_escalator #(.NUM_TIMERS(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_expire(tmr_expire), .irq_local(irq_local), .irq_fast(irq_fast),
        .irq_remote(irq_remote), .rst_debug(rst_debug), .rst_por(rst_por)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_cfg, m_armed, m_run, m_cnt, m_stage;
    int m_il, m_if, m_ir, m_rd, m_rp;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 0) return m_cfg;
        if (a == 1) return (m_stage << 4) | m_run;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_armed = 0; m_run = 0; m_cnt = 0; m_stage = 0;
            m_il = 0; m_if = 0; m_ir = 0; m_rd = 0; m_rp = 0;
        end else begin
            int src, per, en;
            m_rd = 0; m_rp = 0;
            src = m_cfg & 15;
            per = (m_cfg >> 4) & 255;
            if (per == 0) per = 1;
            if (m_run != 0 && m_stage < 5 && src < NT && tmr_expire[src] === 1'b1) begin
                m_cnt++;
                if (m_cnt >= per) begin
                    m_cnt = 0;
                    m_stage++;
                    en = (m_cfg >> (11 + m_stage)) & 1;
                    if (en != 0) begin
                        case (m_stage)
                            1: m_il = 1;
                            2: m_if = 1;
                            3: m_ir = 1;
                            4: m_rd = 1;
                            default: m_rp = 1;
                        endcase
                    end
                end
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) m_cfg = int'(wr_data) & 32'h1FFFF;
                else if (wr_addr == 2'd2) m_armed = (wr_data == KEY) ? 1 : 0;
                else if (wr_addr == 2'd1) begin
                    if (m_armed != 0 && wr_data[1:0] != 2'b00) begin
                        m_run = wr_data[1] ? 0 : 1;
                        m_cnt = 0; m_stage = 0;
                        m_il = 0; m_if = 0; m_ir = 0; m_rd = 0; m_rp = 0;
                    end
                    m_armed = 0;
                end
            end
        end
        #(CLK_PERIOD/4);
        if (rst_n) begin
            check("R9", "model irq_local", irq_local, m_il);
            check("R9", "model irq_fast", irq_fast, m_if);
            check("R9", "model irq_remote", irq_remote, m_ir);
            check("R9", "model rst_debug", rst_debug, m_rd);
            check("R9", "model rst_por", rst_por, m_rp);
            check("R11", "model rd_data", rd_data, model_read(int'(rd_addr)));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [31:0] d);
        wr(2'd2, KEY);
        wr(2'd1, d);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        tmr_expire = NT'(1) << idx;
        @(negedge clk);
        tmr_expire = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] cfgw(input int src, input int per, input int en);
        return 32'((en << 12) | (per << 4) | src);
    endfunction

    task automatic outs(input string req, input logic [4:0] exp);
        check(req, "outputs {por,dbg,rem,fast,loc}",
              {rst_por, rst_debug, irq_remote, irq_fast, irq_local}, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        outs("R12", 5'b0);
        rd(2'd0, d); check("R12", "cfg after reset", d, 0);
        rd(2'd1, d); check("R12", "status after reset", d, 0);

        // R1 config layout and readback width
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R1", "cfg readback", d, 32'h1FFFF);

        // R6 command without unlock ignored
        wr(2'd0, cfgw(3, 2, 31));
        wr(2'd1, 32'h1);
        rd(2'd1, d); check("R6", "start without unlock", d, 0);
        wr(2'd2, 32'h0000_C45B);
        wr(2'd1, 32'h1);
        rd(2'd1, d); check("R6", "start after wrong word", d, 0);

        // full ladder, period 2, all enabled
        cmd(32'h1);
        rd(2'd1, d); check("R7", "start honoured", d, 1);
        pulse(5); pulse(5);
        rd(2'd1, d); check("R2", "non-selected timer ignored", d, 1);
        pulse(3);
        outs("R3", 5'b00000);
        pulse(3);
        outs("R4", 5'b00001);
        rd(2'd1, d); check("R3", "step 1 after two pulses", d, 32'h11);
        pulse(3); pulse(3);
        outs("R4", 5'b00011);
        pulse(3); pulse(3);
        outs("R4", 5'b00111);
        pulse(3); pulse(3);
        outs("R4", 5'b01111);
        @(negedge clk);
        outs("R9", 5'b00111);
        pulse(3); pulse(3);
        outs("R4", 5'b10111);
        rd(2'd1, d); check("R4", "step 5", d, 32'h51);
        @(negedge clk);
        outs("R9", 5'b00111);
        for (int i = 0; i < 6; i++) pulse(3);
        outs("R10", 5'b00111);
        rd(2'd1, d); check("R10", "step stays 5", d, 32'h51);

        // R8 disable clears
        cmd(32'h2);
        outs("R8", 5'b0);
        rd(2'd1, d); check("R8", "status after disable", d, 0);
        pulse(3); pulse(3);
        rd(2'd1, d); check("R8", "no counting while stopped", d, 0);

        // R5 only final step enabled, R3 period 0
        wr(2'd0, cfgw(7, 0, 16));
        cmd(32'h1);
        for (int i = 0; i < 4; i++) pulse(7);
        outs("R5", 5'b00000);
        rd(2'd1, d); check("R3", "period 0 counts each pulse", d, 32'h41);
        pulse(7);
        outs("R5", 5'b10000);

        // R7 both bits: disable wins
        cmd(32'h3);
        rd(2'd1, d); check("R7", "both bits disable", d, 0);

        // R6 unlock consumed by a command
        wr(2'd0, cfgw(0, 1, 31));
        cmd(32'h1);
        pulse(0);
        outs("R6", 5'b00001);
        wr(2'd1, 32'h1);
        rd(2'd1, d); check("R6", "second start without unlock", d, 32'h11);
        outs("R6", 5'b00001);
        wr(2'd2, KEY);
        wr(2'd1, 32'h0);
        wr(2'd1, 32'h2);
        rd(2'd1, d); check("R6", "unlock consumed by empty command", d, 32'h11);

        // R9 restart clears irq
        cmd(32'h1);
        outs("R9", 5'b0);

        // R2 out-of-range source
        wr(2'd0, cfgw(12, 1, 31));
        cmd(32'h1);
        for (int i = 0; i < NT; i++) pulse(i);
        rd(2'd1, d); check("R2", "out-of-range source", d, 1);
        outs("R2", 5'b0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule